// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Sequencer

This block drives a 12-bit successive-approximation converter that sits on a three-wire serial link. It produces a convert strobe, an active-low chip select and a serial clock, and it reads the converter's serial data line. Every analog timing minimum is a parameter counted in system-clock cycles, rounded up by the integrator. These minimums are the strobe width, the conversion time, the chip-select lead before the first clock edge, the serial-clock half period and the quiet gap before the next conversion. After reset the block waits out the converter's power-up time. It then serves conversion requests. A request comes either from a one-cycle start pulse or from an internal sample-rate timer that runs while auto mode is enabled.

A frame steps through seven named states. `ST_PWRUP` waits out power-up and leaves for `ST_IDLE` when its timer expires. `ST_IDLE` goes to `ST_CONV` on a start pulse, a timer tick or a held request. `ST_CONV` drives the convert strobe and leaves for `ST_WAIT` on expiry. `ST_WAIT` covers the conversion time and leaves for `ST_CSSU` on expiry. `ST_CSSU` pulls chip select low ahead of the clock and leaves for `ST_SHIFT` on expiry. `ST_SHIFT` bursts exactly 12 clock pulses and leaves for `ST_QUIET` on the final falling edge. `ST_QUIET` holds everything idle and returns to `ST_IDLE` on expiry.

The serial clock is active only inside `ST_SHIFT`, so it never runs while the converter acquires. A request that arrives while the block is not idle is folded into one held request. That request is served after the quiet gap. The result is presented as a 12-bit word with a one-cycle valid strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy_o` is 1, `cs_n_o` is 1, and `convst_o`, `sclk_o`, `valid_o` and `data_o` are 0. No conversion starts within the first `PWRUP_CYC` clock edges. A start request made during that time is held, and its convert strobe rises after clock edge `PWRUP_CYC + 1`.
- R2: A start request seen in idle raises `convst_o` one cycle later. `convst_o` then stays high for exactly `CONV_PULSE_CYC` cycles, with `cs_n_o` high throughout.
- R3: `cs_n_o` falls exactly `CONV_WAIT_CYC` cycles after `convst_o` falls.
- R4: The first rising edge of `sclk_o` comes `CS_SETUP_CYC + SCLK_HALF_CYC` cycles after `cs_n_o` falls. Every high phase and every low phase of `sclk_o` within a frame lasts `SCLK_HALF_CYC` cycles.
- R5: Each frame has exactly 12 rising edges of `sclk_o`. `sclk_o` is 0 whenever `cs_n_o` is 1.
- R6: Bits are taken MSB first, each one sampled during the high phase of its serial-clock pulse. The first pulse carries bit 11, which the converter presents when chip select falls. Each later bit appears after a falling edge. `data_o` equals the 12 bits in that order.
- R7: `valid_o` is high for exactly one cycle per frame. That cycle is the first one in which `cs_n_o` is high again, and `data_o` already holds the new result in it. `data_o` keeps its value until the next frame completes.
- R8: A held request raises the next `convst_o` exactly `QUIET_CYC + 1` cycles after the final falling edge of `sclk_o`.
- R9: Any number of start requests made while the block is not idle produce exactly one further frame.
- R10: While `auto_en_i` is 1, conversions start every `SAMPLE_PERIOD_CYC` cycles, provided a frame fits in that period. Once `auto_en_i` is 0, no further conversions start.
- R11: `busy_o` is 1 in every state except idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| auto_en_i | input | 1 | Enables the free-running sample-rate timer |
| sdo_i | input | 1 | Serial data from the converter |
| convst_o | output | 1 | Convert strobe, active high |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Burst serial clock |
| data_o | output | RES_BITS | Last conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | High in every state except idle |

## Verification
The hardest case to reach from the ports is the held request: a start that arrives while the block is converting, waiting or shifting. It must collapse with any others into one extra frame, and that frame must still respect the quiet gap. The directed pending test issues one start and then two more in the middle of the first frame's conversion and shift phases. It then counts the frames that follow and times the gap from the last serial-clock fall to the next strobe. A start pulse placed inside the power-up window covers the same holding path from the other side.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_CONV  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_CSSU  = 3'd4,
        ST_SHIFT = 3'd5,
        ST_QUIET = 3'd6
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Down-counter used for every timed state; expired when it reaches zero.
module seq_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sclk_gen.sv
// Burst serial clock: low phase first, a fixed number of pulses per enable.
module sclk_gen #(
    parameter int HALF   = 1,
    parameter int PULSES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic sample,
    output logic last_fall
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PW = $clog2(PULSES + 1);

    logic [HW-1:0] half_cnt;
    logic [PW-1:0] pcnt;
    logic          sclk_q;
    logic          phase_end;

    assign phase_end = (half_cnt == HW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            sclk_q   <= 1'b0;
            pcnt     <= '0;
        end else if (!en) begin
            half_cnt <= '0;
            sclk_q   <= 1'b0;
            pcnt     <= '0;
        end else if (phase_end) begin
            half_cnt <= '0;
            sclk_q   <= ~sclk_q;
            if (sclk_q) begin
                pcnt <= pcnt + 1'b1;
            end
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assign sclk      = sclk_q;
    assign sample    = en & sclk_q & (half_cnt == '0);
    assign last_fall = en & sclk_q & phase_end & (pcnt == PW'(PULSES - 1));

    // R5: the pulse count never passes the frame length
    a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pcnt < PW'(PULSES)));
endmodule

// File: rtl/rx_shift.sv
// MSB-first deserializer; the result register updates on the last bit.
module rx_shift #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            sample,
    input  logic            sdo,
    output logic [BITS-1:0] word
);
    localparam int CW = $clog2(BITS + 1);

    logic [BITS-1:0] sr;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            cnt  <= '0;
            word <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (sample) begin
            sr <= {sr[BITS-2:0], sdo};
            if (cnt == CW'(BITS - 1)) begin
                word <= {sr[BITS-2:0], sdo};
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: no more than BITS samples are taken per frame
    a_r6_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (cnt < CW'(BITS)));
endmodule

// File: rtl/rate_tick.sv
// Free-running sample-rate timer, cleared while disabled.
module rate_tick #(
    parameter int PERIOD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en & wrap;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS          = 12,
    parameter int PWRUP_CYC         = 10000,
    parameter int CONV_PULSE_CYC    = 1,
    parameter int CONV_WAIT_CYC     = 66,
    parameter int CS_SETUP_CYC      = 2,
    parameter int SCLK_HALF_CYC     = 1,
    parameter int QUIET_CYC         = 5,
    parameter int SAMPLE_PERIOD_CYC = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                auto_en_i,
    input  logic                sdo_i,
    output logic                convst_o,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic [RES_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                busy_o
);
    localparam int TMAX = imax(imax(PWRUP_CYC, CONV_PULSE_CYC),
                               imax(imax(CONV_WAIT_CYC, CS_SETUP_CYC), QUIET_CYC));
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e    state, state_n;
    logic          t_exp;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          tick;
    logic          pend;
    logic          req_now;
    logic          shift_en;
    logic          sample;
    logic          last_fall;
    logic          valid_q;

    // ---------------- sub-blocks ----------------
    seq_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    rate_tick #(.PERIOD(SAMPLE_PERIOD_CYC)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (auto_en_i),
        .tick  (tick)
    );

    sclk_gen #(.HALF(SCLK_HALF_CYC), .PULSES(RES_BITS)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (shift_en),
        .sclk      (sclk_o),
        .sample    (sample),
        .last_fall (last_fall)
    );

    rx_shift #(.BITS(RES_BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!shift_en),
        .sample (sample),
        .sdo    (sdo_i),
        .word   (data_o)
    );

    // ---------------- next state ----------------
    assign req_now = start_i | tick | pend;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_PWRUP: if (t_exp)     state_n = ST_IDLE;
            ST_IDLE:  if (req_now)   state_n = ST_CONV;
            ST_CONV:  if (t_exp)     state_n = ST_WAIT;
            ST_WAIT:  if (t_exp)     state_n = ST_CSSU;
            ST_CSSU:  if (t_exp)     state_n = ST_SHIFT;
            ST_SHIFT: if (last_fall) state_n = ST_QUIET;
            ST_QUIET: if (t_exp)     state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // timer reload on every state change with the new state's length
    always_comb begin
        t_load = (state_n != state);
        unique case (state_n)
            ST_CONV:  t_val = TW'(CONV_PULSE_CYC - 1);
            ST_WAIT:  t_val = TW'(CONV_WAIT_CYC - 1);
            ST_CSSU:  t_val = TW'(CS_SETUP_CYC - 1);
            ST_QUIET: t_val = TW'(QUIET_CYC - 1);
            default:  t_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PWRUP;
            pend    <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            state   <= state_n;
            valid_q <= (state == ST_SHIFT) && last_fall;
            if (state == ST_IDLE) begin
                pend <= 1'b0;
            end else if (start_i || tick) begin
                pend <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        convst_o = (state == ST_CONV);
        cs_n_o   = !((state == ST_CSSU) || (state == ST_SHIFT));
        busy_o   = (state != ST_IDLE);
        shift_en = (state == ST_SHIFT);
        valid_o  = valid_q;
    end

    // ---------------- assertions ----------------
    // R5: the serial clock stays low while chip select is released
    a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2: the convert strobe never overlaps chip select or clock activity
    a_r2_convst_alone: assert property (@(posedge clk) disable iff (!rst_n)
        convst_o |-> (cs_n_o && !sclk_o));

    // R7: valid lasts one cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: valid follows the release of chip select at the end of shifting
    a_r7_valid_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && $past(!cs_n_o)));

    // R9: a held request is served as soon as the block returns to idle
    a_r9_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pend) |=> (state == ST_CONV));

    // R11: busy is high whenever the strobe or chip select is active
    a_r11_busy_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (convst_o || !cs_n_o) |-> busy_o);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PWRUP  = 30;
    localparam int CPULSE = 2;
    localparam int CWAIT  = 7;
    localparam int CSSU   = 2;
    localparam int HALF   = 2;
    localparam int QUIET  = 5;
    localparam int PERIOD = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        auto_en_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        convst_o, cs_n_o, sclk_o, valid_o, busy_o;
    logic [11:0] data_o;

    adc_seq_ctrl #(
        .RES_BITS(12), .PWRUP_CYC(PWRUP), .CONV_PULSE_CYC(CPULSE),
        .CONV_WAIT_CYC(CWAIT), .CS_SETUP_CYC(CSSU), .SCLK_HALF_CYC(HALF),
        .QUIET_CYC(QUIET), .SAMPLE_PERIOD_CYC(PERIOD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
        .sdo_i(sdo_i), .convst_o(convst_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .data_o(data_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // converter model: MSB on chip-select fall, next bit after each falling clock
    logic [11:0] tx_word = 12'h000;
    int          bit_idx = 11;
    always @(negedge cs_n_o) begin
        #1;
        bit_idx = 11;
        sdo_i = tx_word[11];
    end
    always @(negedge sclk_o) begin
        #1;
        if (!cs_n_o && bit_idx > 0) begin
            bit_idx--;
            sdo_i = tx_word[bit_idx];
        end
    end

    // port monitor, sampled on the falling system-clock edge
    int cyc = 0, n_conv = 0, n_valid = 0;
    int t_cv_rise = 0, t_cv_fall = 0, t_cs_fall = 0, t_cs_rise = 0;
    int t_rise = 0, t_last_fall = 0, t_start = 0;
    int cv_width = 0, cv_interval = 0, cs_gap = 0, first_rise = 0;
    int rises = 0, frame_rises = 0, bad_phase = 0, bad_idle = 0, bad_valid = 0;
    int valid_lag = 0, quiet_gap = 0, last_data = 0;
    logic p_cv = 1'b0, p_cs = 1'b1, p_sk = 1'b0, p_vl = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            p_cv = 1'b0; p_cs = 1'b1; p_sk = 1'b0; p_vl = 1'b0;
        end else begin
            cyc++;
            if (convst_o && !p_cv) begin
                n_conv++;
                cv_interval = cyc - t_cv_rise;
                t_cv_rise = cyc;
                quiet_gap = cyc - t_last_fall;
            end
            if (!convst_o && p_cv) begin
                cv_width = cyc - t_cv_rise;
                t_cv_fall = cyc;
            end
            if (!cs_n_o && p_cs) begin
                t_cs_fall = cyc;
                cs_gap = cyc - t_cv_fall;
                rises = 0;
            end
            if (sclk_o && !p_sk) begin
                if (rises == 0) first_rise = cyc - t_cs_fall;
                else if (cyc - t_last_fall != HALF) bad_phase++;
                rises++;
                t_rise = cyc;
            end
            if (!sclk_o && p_sk) begin
                if (cyc - t_rise != HALF) bad_phase++;
                t_last_fall = cyc;
            end
            if (cs_n_o && !p_cs) begin
                frame_rises = rises;
                t_cs_rise = cyc;
            end
            if (sclk_o && cs_n_o) bad_idle++;
            if (valid_o) begin
                n_valid++;
                last_data = int'(data_o);
                valid_lag = cyc - t_cs_rise;
                if (p_vl) bad_valid++;
            end
            p_cv = convst_o; p_cs = cs_n_o; p_sk = sclk_o; p_vl = valid_o;
        end
    end

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        #1;
        start_i = 1'b1;
        t_start = cyc;
        @(negedge clk);
        #1;
        start_i = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        int n0 = n_valid;
        for (int i = 0; i < 600 && n_valid == n0; i++) begin
            @(negedge clk);
            #2;
        end
        if (n_valid == n0) chk({tag, " result timeout"}, 0, 1);
    endtask

    task automatic t_reset();
        #2;
        chk("R1 busy at reset", int'(busy_o), 1);
        chk("R1 cs_n at reset", int'(cs_n_o), 1);
        chk("R1 convst at reset", int'(convst_o), 0);
        chk("R1 sclk at reset", int'(sclk_o), 0);
        chk("R1 valid at reset", int'(valid_o), 0);
        chk("R1 data at reset", int'(data_o), 0);
        tx_word = 12'h3C6;
        idle_cycles(4);
        pulse_start();
        wait_valid("R1");
        chk("R1 first strobe cycle", t_cv_rise, PWRUP + 1);
        chk("R1 single frame", n_conv, 1);
        chk("R1 held request data", last_data, 12'h3C6);
        idle_cycles(QUIET + 3);
    endtask

    task automatic t_single();
        tx_word = 12'hA5C;
        pulse_start();
        idle_cycles(6);
        chk("R11 busy mid frame", int'(busy_o), 1);
        wait_valid("R6");
        chk("R2 strobe latency", t_cv_rise - t_start, 1);
        chk("R2 strobe width", cv_width, CPULSE);
        chk("R3 conversion wait", cs_gap, CWAIT);
        chk("R4 first edge delay", first_rise, CSSU + HALF);
        chk("R4 phase errors", bad_phase, 0);
        chk("R5 pulses per frame", frame_rises, 12);
        chk("R6 data 0xA5C", last_data, 12'hA5C);
        chk("R7 valid lag", valid_lag, 0);
        idle_cycles(QUIET + 3);
        chk("R11 busy in idle", int'(busy_o), 0);
        chk("R7 data held", int'(data_o), 12'hA5C);
    endtask

    task automatic t_patterns();
        logic [11:0] pats [4] = '{12'h000, 12'hFFF, 12'h801, 12'h001};
        foreach (pats[k]) begin
            tx_word = pats[k];
            pulse_start();
            wait_valid("R6");
            chk("R6 pattern data", last_data, int'(pats[k]));
            idle_cycles(QUIET + 3);
        end
    endtask

    task automatic t_pending();
        int c0 = n_conv;
        int v0 = n_valid;
        tx_word = 12'h5A3;
        pulse_start();
        idle_cycles(4);
        pulse_start();
        idle_cycles(20);
        pulse_start();
        idle_cycles(250);
        chk("R9 frames from pending", n_conv - c0, 2);
        chk("R9 results from pending", n_valid - v0, 2);
        chk("R8 quiet gap", quiet_gap, QUIET + 1);
        chk("R7 valid pulses single", bad_valid, 0);
    endtask

    task automatic t_auto();
        int c0;
        tx_word = 12'h777;
        @(negedge clk);
        #1;
        auto_en_i = 1'b1;
        wait_valid("R10");
        wait_valid("R10");
        wait_valid("R10");
        chk("R10 sample period", cv_interval, PERIOD);
        chk("R10 auto data", last_data, 12'h777);
        @(negedge clk);
        #1;
        auto_en_i = 1'b0;
        c0 = n_conv;
        idle_cycles(300);
        chk("R10 stop after disable", n_conv, c0);
        chk("R5 clock idle with cs high", bad_idle, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_patterns();
        t_pending();
        t_auto();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule